// File: doc/BRIEF.md
# GPIO Data Port with Input Glitch Filter

This block is a 32-pin general-purpose I/O data port that sits behind a simple 32-bit memory-mapped register bus. Software chooses the direction of each pin and drives output levels through a data-out register. Bits can be changed atomically through separate set and clear registers, so no read-modify-write is needed. Input pins are resynchronised to the bus clock by a two-flop synchroniser. Each pin can then pass through its own glitch filter before it reaches the data-in register.

The glitch filter accepts a new input level only after that level has stayed unchanged for a programmed number of filter ticks. Ticks come either from every bus clock or from the bus clock divided by sixteen. The filtered input vector also leaves the block on a port, so that a separate interrupt block can use it. The port also holds an identification word, a configuration word, and two pull registers that only store their values.

Top module: `gpio_data_port`

## Requirements
- R1: After reset, direction, data-out, filter-enable, filter-control and both pull registers read zero, and `pin_oe` and `pin_out` are all zero.
- R2: The direction register (offset 0x28) drives `pin_oe` bit for bit. A 1 makes the pin an output and a 0 makes it an input.
- R3: A write to data-out (offset 0x24) replaces the whole word. The word reads back from 0x24 and appears on `pin_out` after that clock edge.
- R4: A write to the set register (offset 0x30) sets each data-out bit whose written bit is 1 and leaves all other bits unchanged.
- R5: A write to the clear register (offset 0x2C) clears each data-out bit whose written bit is 1 and leaves all other bits unchanged.
- R6: For a pin whose filter is off, the data-in register (offset 0x20) and `pin_filtered` show the level that `pin_in` had two clock edges earlier.
- R7: The filter-enable register (offset 0x70) has one bit per pin. Let N be bits [7:0] of filter control. For a pin whose enable bit is set, a new level is taken only after it has differed from the accepted level for N+1 consecutive ticks. With N=3 and a tick on every clock, a 3-clock pulse is removed and a 4-clock pulse passes. Pins whose enable bit is clear are not filtered.
- R8: Bit 31 of filter control (offset 0x74) selects the tick source. A 1 gives one tick every 16 bus clocks and a 0 gives a tick on every bus clock.
- R9: The identification word (0x00) reads 0x47500101. The configuration word (0x10) reads bit 31 = 1 (filter present) with the pin count (32) in bits [7:0]. Writes to 0x00, 0x10 and 0x20 change nothing.
- R10: Reads of an unmapped offset return zero. The pull-enable (0x40) and pull-type (0x44) registers store and read back any 32-bit word.
- R11: Filter control keeps only bits 31 and [7:0]. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output levels (data-out register) |
| pin_oe | output | 32 | Output enables (direction register) |
| pin_filtered | output | 32 | Synchronised and filtered input levels |

## Verification
The bench aims at the exact filter threshold: a 3-clock pulse must vanish and a 4-clock pulse must pass. A counter that is off by one in its compare would either remove both pulses or let both through. In divided-tick mode, a 10-clock pulse must be removed while a 40-clock pulse passes. A tick source stuck at every clock would let the short pulse through. Set and clear are checked against bits that must survive, so a design that writes the word instead of merging it would destroy them. The bench also checks the two-edge input latency of an unfiltered pin at both edges, and it checks that writes to read-only offsets and writes to the unused bits of filter control leave their readbacks unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [7:0] OFS_IDENT  = 8'h00;
  localparam logic [7:0] OFS_CONFIG = 8'h10;
  localparam logic [7:0] OFS_DIN    = 8'h20;
  localparam logic [7:0] OFS_DOUT   = 8'h24;
  localparam logic [7:0] OFS_DIR    = 8'h28;
  localparam logic [7:0] OFS_CLR    = 8'h2C;
  localparam logic [7:0] OFS_SET    = 8'h30;
  localparam logic [7:0] OFS_PULLEN = 8'h40;
  localparam logic [7:0] OFS_PULLTY = 8'h44;
  localparam logic [7:0] OFS_FLTEN  = 8'h70;
  localparam logic [7:0] OFS_FLTCTL = 8'h74;

  typedef enum logic [1:0] {
    OUT_KEEP  = 2'd0,
    OUT_LOAD  = 2'd1,
    OUT_SET   = 2'd2,
    OUT_CLEAR = 2'd3
  } out_op_e;

  // next data-out word for a given operation
  function automatic logic [31:0] out_next(input logic [31:0] cur,
                                           input logic [31:0] w,
                                           input out_op_e op);
    case (op)
      OUT_LOAD:  return w;
      OUT_SET:   return cur | w;
      OUT_CLEAR: return cur & ~w;
      default:   return cur;
    endcase
  endfunction

  // configuration word: filter present flag and pin count
  function automatic logic [31:0] config_word(input int npin);
    logic [31:0] v;
    v = 32'h8000_0000;
    v[7:0] = 8'(npin);
    return v;
  endfunction

  // filter control keeps only the tick-source bit and the threshold byte
  function automatic logic [31:0] fltctl_mask(input logic [31:0] w);
    return w & 32'h8000_00FF;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_tick.sv
module gpio_tick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!div_en)         cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = div_en ? (cnt_q == LAST) : 1'b1;
endmodule

// File: rtl/gpio_filter.sv
module gpio_filter #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [W-1:0]     dout
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic             level_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level_q <= 1'b0;
        run_q   <= '0;
      end else if (!en[i]) begin
        level_q <= din[i];
        run_q   <= '0;
      end else if (din[i] == level_q) begin
        run_q   <= '0;
      end else if (tick) begin
        if (run_q == limit) begin
          level_q <= din[i];
          run_q   <= '0;
        end else begin
          run_q   <= run_q + 1'b1;
        end
      end
    end

    assign dout[i] = en[i] ? level_q : din[i];
  end
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_port_pkg::*;
#(
  parameter int          NPIN        = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int          TICK_DIV    = 16,
  parameter int          THR_W       = 8,
  parameter logic [31:0] IDENT_WORD  = 32'h4750_0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic [31:0] pin_filtered
);
  localparam logic [31:0] CONFIG_WORD = config_word(NPIN);

  logic [31:0] dir_q, dout_q, pullen_q, pullty_q, flten_q, fltctl_q;
  logic        wr_hit;
  out_op_e     out_op;
  logic [31:0] pin_sync;
  logic        deb_tick;
  logic        div_sel;

  assign wr_hit  = bus_sel && bus_wr;
  assign div_sel = fltctl_q[31];

  always_comb begin
    out_op = OUT_KEEP;
    if (wr_hit) begin
      case (bus_addr)
        OFS_DOUT: out_op = OUT_LOAD;
        OFS_SET:  out_op = OUT_SET;
        OFS_CLR:  out_op = OUT_CLEAR;
        default:  out_op = OUT_KEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= out_next(dout_q, bus_wdata, out_op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      pullen_q <= '0;
      pullty_q <= '0;
      flten_q  <= '0;
      fltctl_q <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        OFS_DIR:    dir_q    <= bus_wdata;
        OFS_PULLEN: pullen_q <= bus_wdata;
        OFS_PULLTY: pullty_q <= bus_wdata;
        OFS_FLTEN:  flten_q  <= bus_wdata;
        OFS_FLTCTL: fltctl_q <= fltctl_mask(bus_wdata);
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(32), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_en (div_sel),
    .tick   (deb_tick)
  );

  gpio_filter #(.W(32), .CNT_W(THR_W)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_sync),
    .en    (flten_q),
    .tick  (deb_tick),
    .limit (fltctl_q[THR_W-1:0]),
    .dout  (pin_filtered)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_IDENT:  bus_rdata = IDENT_WORD;
        OFS_CONFIG: bus_rdata = CONFIG_WORD;
        OFS_DIN:    bus_rdata = pin_filtered;
        OFS_DOUT:   bus_rdata = dout_q;
        OFS_DIR:    bus_rdata = dir_q;
        OFS_PULLEN: bus_rdata = pullen_q;
        OFS_PULLTY: bus_rdata = pullty_q;
        OFS_FLTEN:  bus_rdata = flten_q;
        OFS_FLTCTL: bus_rdata = fltctl_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_data_port_chk.sv
module gpio_data_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_in,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic [31:0] pin_filtered,
  input logic [31:0] flt_en,
  input logic        div_sel,
  input logic        deb_tick
);
  logic [1:0] cyc_q;
  logic       unmapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  assign unmapped = !(bus_addr inside {8'h00, 8'h10, 8'h20, 8'h24, 8'h28, 8'h2C,
                                       8'h30, 8'h40, 8'h44, 8'h70, 8'h74});

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 8'h28 |=> pin_oe == $past(bus_wdata)); // R2

  AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 8'h24 |=> pin_out == $past(bus_wdata)); // R3

  AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 8'h30 |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R4

  AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 8'h2C |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R5

  AST_RAW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q == 2'd3 && !flt_en[0] |-> pin_filtered[0] == $past(pin_in[0], 2)); // R6

  AST_FILTER_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q != 2'd0 && flt_en[0] && $past(flt_en[0]) && !$past(deb_tick) |-> $stable(pin_filtered[0])); // R7

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q != 2'd0 && div_sel && $past(div_sel) && $past(deb_tick) |-> !deb_tick); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && unmapped |-> bus_rdata == 32'h0); // R10
endmodule

bind gpio_data_port gpio_data_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .pin_in       (pin_in),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .pin_filtered (pin_filtered),
  .flt_en       (flten_q),
  .div_sel      (div_sel),
  .deb_tick     (deb_tick)
);

// File: tb/tb_gpio_data_port.sv
module tb_gpio_data_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_filtered;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gpio_data_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_filtered(pin_filtered)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // drive a high pulse of given width on one pin, watch the filtered output
  task automatic pulse(input int pin, input int width, input int window, output logic seen);
    seen = 1'b0;
    for (int t = 0; t < width + window; t++) begin
      @(negedge clk);
      if (pin_filtered[pin]) seen = 1'b1;
      pin_in[pin] = (t < width);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h28, v); chk("R1 dir", v, 32'h0);
    rd(8'h24, v); chk("R1 dout", v, 32'h0);
    rd(8'h70, v); chk("R1 flten", v, 32'h0);
    rd(8'h74, v); chk("R1 fltctl", v, 32'h0);
    rd(8'h40, v); chk("R1 pullen", v, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(8'h28, 32'hF0F0_00A5);
    chk("R2 pin_oe", pin_oe, 32'hF0F0_00A5);
    rd(8'h28, v); chk("R2 readback", v, 32'hF0F0_00A5);
    wr(8'h28, 32'h0000_0001);
    chk("R2 pin_oe single", pin_oe, 32'h0000_0001);
  endtask

  task automatic t_dout;
    logic [31:0] v;
    wr(8'h24, 32'h1234_5678);
    chk("R3 pin_out", pin_out, 32'h1234_5678);
    rd(8'h24, v); chk("R3 readback", v, 32'h1234_5678);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(8'h24, 32'hA5A5_0000);
    wr(8'h30, 32'h0000_00FF);
    chk("R4 set merge", pin_out, 32'hA5A5_00FF);
    wr(8'h30, 32'h8000_0001);
    chk("R4 set overlap", pin_out, 32'hA5A5_00FF);
    wr(8'h2C, 32'hA000_000F);
    chk("R5 clear merge", pin_out, 32'h05A5_00F0);
    rd(8'h24, v); chk("R5 readback", v, 32'h05A5_00F0);
    wr(8'h2C, 32'h0);
    chk("R5 clear zero", pin_out, 32'h05A5_00F0);
  endtask

  task automatic t_datain;
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R6 one edge old", pin_filtered, 32'h0);
    @(negedge clk);
    chk("R6 two edges new", pin_filtered, 32'hDEAD_BEEF);
    rd(8'h20, v); chk("R6 datain read", v, 32'hDEAD_BEEF);
    pin_in = 32'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_filter_fast;
    logic seen;
    wr(8'h74, 32'h0000_0003);
    wr(8'h70, 32'h0000_0020);
    repeat (3) @(negedge clk);
    pulse(5, 3, 12, seen); chk("R7 3-clock pulse removed", {31'b0, seen}, 32'h0);
    pulse(5, 4, 12, seen); chk("R7 4-clock pulse passes", {31'b0, seen}, 32'h1);
    chk("R7 returns low", {31'b0, pin_filtered[5]}, 32'h0);
    pulse(6, 1, 6, seen); chk("R7 unfiltered pin passes", {31'b0, seen}, 32'h1);
  endtask

  task automatic t_filter_div;
    logic seen;
    wr(8'h74, 32'h8000_0001);
    wr(8'h70, 32'h0000_0080);
    repeat (3) @(negedge clk);
    pulse(7, 10, 40, seen); chk("R8 slow tick removes 10", {31'b0, seen}, 32'h0);
    pulse(7, 40, 60, seen); chk("R8 slow tick passes 40", {31'b0, seen}, 32'h1);
    chk("R8 returns low", {31'b0, pin_filtered[7]}, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R9 ident", v, 32'h4750_0101);
    rd(8'h10, v); chk("R9 config", v, 32'h8000_0020);
    rd(8'h20, v); chk("R9 datain unchanged", v, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    rd(8'h50, v); chk("R10 unmapped 0x50", v, 32'h0);
    rd(8'h04, v); chk("R10 unmapped 0x04", v, 32'h0);
    wr(8'h40, 32'hCAFE_F00D);
    wr(8'h44, 32'h1357_9BDF);
    rd(8'h40, v); chk("R10 pull enable", v, 32'hCAFE_F00D);
    rd(8'h44, v); chk("R10 pull type", v, 32'h1357_9BDF);
    wr(8'h74, 32'hFFFF_FFFF);
    rd(8'h74, v); chk("R11 ctl mask", v, 32'h8000_00FF);
    wr(8'h74, 32'h7FFF_FF00);
    rd(8'h74, v); chk("R11 ctl mask low", v, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_dout();
    t_setclr();
    t_datain();
    t_filter_fast();
    t_filter_div();
    t_readonly();
    t_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule